// File: doc/BRIEF.md
# Ring Node Receive and Forward Path

This block sits on the receive side of one node in a unidirectional ring of nodes that share a memory image. Each message arriving from the upstream neighbour carries a source node number, a word address and a data word. A data message from another node is written into the local memory copy. In the same cycle it is queued for retransmission to the downstream neighbour, so that the update travels around the ring.

A node drops any message that it originated itself, because that message has completed its round trip. One node in the ring is strapped as master. The master marks every message it forwards with a loop flag. A marked message that reaches the master a second time has lost its originator, and the master discards it, so no message can circulate for ever. Forwarded messages wait in a small FIFO that feeds a downstream transmit arbiter. When the FIFO is full, the receive stream is held off rather than dropped.

The block also gives an activity pulse for each retransmitted message. It raises an interrupt pulse when a memory update arrives from one selectable source node.

Top module: `ring_rx_node`

## Requirements
- R1: A data message (type bit 1) accepted from another node, and not discarded, gives exactly one memory write in the next cycle, using the message's address and data.
- R2: A status message (type bit 0) from another node writes no memory but is forwarded like a data message.
- R3: A message whose 8-bit source field equals `node_addr` is neither forwarded nor written to memory.
- R4: With `master_en` low, a forwarded message leaves the node bit-for-bit unchanged, and its loop flag is kept as it arrived.
- R5: With `master_en` high, every forwarded message leaves with its loop flag (bit 42) set.
- R6: With `master_en` high, an accepted message that arrives with its loop flag set is discarded: no forward, no memory write.
- R7: `net_act` pulses for one cycle in the cycle after each message is accepted for forwarding, and at no other time.
- R8: `irq_pulse` pulses together with a memory write when `irq_en` is high and the written message's source equals `irq_src`.
- R9: Forwarded messages leave in arrival order. While `tx_valid` is high and `tx_ready` is low, `tx_msg` holds steady.
- R10: `rx_ready` is low exactly while the FIFO holds `FIFO_DEPTH` messages, and no accepted message is lost.
- R11: After reset, `rx_ready` is high and `tx_valid`, `mem_we`, `irq_pulse` and `net_act` are low.

Message layout (44 bits at the default widths): bit 43 is the type, bit 42 is the loop flag, bits 41:34 are the source, bits 33:16 are the word address and bits 15:0 are the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Upstream message present |
| rx_ready | output | 1 | Block can take a message |
| rx_msg | input | MSG_W | Received message |
| tx_valid | output | 1 | Forwarded message present |
| tx_ready | input | 1 | Downstream arbiter takes the message |
| tx_msg | output | MSG_W | Forwarded message |
| mem_we | output | 1 | Local memory write strobe |
| mem_addr | output | ADDR_W | Local memory word address |
| mem_wdata | output | DATA_W | Local memory write data |
| node_addr | input | NODE_W | This node's number |
| master_en | input | 1 | Node acts as ring master |
| irq_en | input | 1 | Enables the source-match interrupt |
| irq_src | input | NODE_W | Source node that raises the interrupt |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| net_act | output | 1 | One-cycle retransmit activity pulse |

## Verification
Some properties are checked by assertions on every cycle. A stalled output message must hold steady. A self-sourced or master-killed message must never reach memory or the activity pulse. An interrupt must never appear without a write. A full FIFO must still present data. Correct ordering across the FIFO, the exact values written, and the loop-flag rewrite are shown by the bench. It checks them against a queue model of the ring rules across scenarios with mixed sources, master and non-master modes, and a FIFO held full under backpressure.

// File: rtl/rn_pkg.sv
package rn_pkg;

    // Routing decision for one received message
    typedef struct packed {
        logic fwd;       // pass downstream
        logic wr;        // update local memory
        logic loop_out;  // loop flag on the forwarded copy
        logic irq;       // source-match interrupt
    } rn_verdict_t;

endpackage

// File: rtl/rn_classify.sv
module rn_classify
    import rn_pkg::*;
#(
    parameter int NODE_W = 8
) (
    input  logic              msg_type,
    input  logic              msg_loop,
    input  logic [NODE_W-1:0] msg_src,
    input  logic [NODE_W-1:0] node_addr,
    input  logic              master_en,
    input  logic              irq_en,
    input  logic [NODE_W-1:0] irq_src,
    output rn_verdict_t       verdict
);

    logic from_self;
    logic orphan;

    always_comb begin
        from_self        = (msg_src == node_addr);
        orphan           = master_en && msg_loop;
        verdict.fwd      = !from_self && !orphan;
        verdict.wr       = msg_type && verdict.fwd;
        verdict.loop_out = msg_loop || master_en;
        verdict.irq      = verdict.wr && irq_en && (msg_src == irq_src);
    end

endmodule

// File: rtl/rn_fwd_fifo.sv
module rn_fwd_fifo #(
    parameter int WIDTH = 44,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    output logic             full,
    input  logic             pop,
    output logic             valid,
    output logic [WIDTH-1:0] dout
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] slot;
        logic [PTR_W-1:0]            wptr;
        logic [PTR_W-1:0]            rptr;
        logic [CNT_W-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && (st_q.cnt != FULL_CNT);
        if (do_push) begin
            st_d.slot[st_q.wptr] = din;
            st_d.wptr = (st_q.wptr == LAST) ? '0 : st_q.wptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rptr = (st_q.rptr == LAST) ? '0 : st_q.rptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full  = (st_q.cnt == FULL_CNT);
    assign valid = (st_q.cnt != '0);
    assign dout  = st_q.slot[st_q.rptr];

endmodule

// File: rtl/ring_rx_node.sv
module ring_rx_node
    import rn_pkg::*;
#(
    parameter int NODE_W     = 8,
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 4,
    localparam int MSG_W     = 2 + NODE_W + ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [MSG_W-1:0]  rx_msg,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [MSG_W-1:0]  tx_msg,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [NODE_W-1:0] node_addr,
    input  logic              master_en,
    input  logic              irq_en,
    input  logic [NODE_W-1:0] irq_src,
    output logic              irq_pulse,
    output logic              net_act
);

    localparam int TYPE_B = MSG_W - 1;
    localparam int LOOP_B = MSG_W - 2;
    localparam int SRC_LO = ADDR_W + DATA_W;
    localparam int ADR_LO = DATA_W;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              irq;
        logic              act;
    } out_st_t;

    rn_verdict_t      verdict;
    logic             fifo_full;
    logic             accept;
    logic             push;
    logic [MSG_W-1:0] fwd_msg;
    out_st_t          out_d, out_q;

    rn_classify #(.NODE_W(NODE_W)) classify_i (
        .msg_type  (rx_msg[TYPE_B]),
        .msg_loop  (rx_msg[LOOP_B]),
        .msg_src   (rx_msg[SRC_LO +: NODE_W]),
        .node_addr (node_addr),
        .master_en (master_en),
        .irq_en    (irq_en),
        .irq_src   (irq_src),
        .verdict   (verdict)
    );

    always_comb begin
        accept  = rx_valid && !fifo_full;
        push    = accept && verdict.fwd;
        fwd_msg = {rx_msg[TYPE_B], verdict.loop_out, rx_msg[LOOP_B-1:0]};

        out_d      = out_q;
        out_d.we   = accept && verdict.wr;
        out_d.irq  = accept && verdict.irq;
        out_d.act  = push;
        if (accept && verdict.wr) begin
            out_d.addr = rx_msg[ADR_LO +: ADDR_W];
            out_d.data = rx_msg[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    rn_fwd_fifo #(.WIDTH(MSG_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (fwd_msg),
        .full  (fifo_full),
        .pop   (tx_ready),
        .valid (tx_valid),
        .dout  (tx_msg)
    );

    assign rx_ready  = !fifo_full;
    assign mem_we    = out_q.we;
    assign mem_addr  = out_q.addr;
    assign mem_wdata = out_q.data;
    assign irq_pulse = out_q.irq;
    assign net_act   = out_q.act;

endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
    parameter int NODE_W = 8,
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int MSG_W  = 44
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [MSG_W-1:0]  rx_msg,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [MSG_W-1:0]  tx_msg,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [NODE_W-1:0] node_addr,
    input logic              master_en,
    input logic              irq_pulse,
    input logic              net_act
);

    localparam int TYPE_B = MSG_W - 1;
    localparam int LOOP_B = MSG_W - 2;
    localparam int SRC_LO = ADDR_W + DATA_W;

    logic took, self_src, killed;
    assign took     = rx_valid && rx_ready;
    assign self_src = rx_msg[SRC_LO +: NODE_W] == node_addr;
    assign killed   = master_en && rx_msg[LOOP_B];

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_msg));

    p_self_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        took && self_src |=> !mem_we && !net_act);

    p_orphan_kill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        took && killed |=> !mem_we && !net_act);

    p_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        took && rx_msg[TYPE_B] && !self_src && !killed
        |=> mem_we && mem_wdata == $past(rx_msg[DATA_W-1:0]));

    p_act_r7: assert property (@(posedge clk) disable iff (!rst_n)
        took && !self_src && !killed |=> net_act);

    p_irq_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> mem_we);

    p_full_has_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> tx_valid);

endmodule

bind ring_rx_node rn_checker #(
    .NODE_W(NODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MSG_W(MSG_W)
) checker_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_msg(rx_msg), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_msg(tx_msg),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .node_addr(node_addr), .master_en(master_en), .irq_pulse(irq_pulse),
    .net_act(net_act)
);

// File: tb/ring_rx_node_tb.sv
`timescale 1ns/1ps
module ring_rx_node_tb_top;

    localparam int DEPTH = 4;
    localparam int MW    = 44;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic          rx_ready;
    logic [MW-1:0] rx_msg = '0;
    logic          tx_valid;
    logic          tx_ready = 1'b0;
    logic [MW-1:0] tx_msg;
    logic          mem_we;
    logic [17:0]   mem_addr;
    logic [15:0]   mem_wdata;
    logic [7:0]    node_addr = 8'h05;
    logic          master_en = 1'b0;
    logic          irq_en = 1'b0;
    logic [7:0]    irq_src = 8'h00;
    logic          irq_pulse;
    logic          net_act;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ring_rx_node dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_msg(rx_msg), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_msg(tx_msg),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .node_addr(node_addr), .master_en(master_en), .irq_en(irq_en),
        .irq_src(irq_src), .irq_pulse(irq_pulse), .net_act(net_act)
    );

    // ---------------- reference model ----------------
    logic [MW-1:0] q[$];
    bit            e_we, e_irq, e_act, last_acc;
    logic [17:0]   e_addr;
    logic [15:0]   e_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            e_we = 0; e_irq = 0; e_act = 0; last_acc = 0;
        end else begin
            int  pre;
            bit  acc, own, dead;
            logic [MW-1:0] m;
            pre  = q.size();
            acc  = rx_valid && (pre < DEPTH);
            m    = rx_msg;
            e_we = 0; e_irq = 0; e_act = 0;
            if (pre > 0 && tx_ready) void'(q.pop_front());
            if (acc) begin
                own  = (m[41:34] == node_addr);
                dead = master_en && m[42];
                if (!own && !dead) begin
                    if (master_en) m[42] = 1'b1;
                    q.push_back(m);
                    e_act = 1;
                    if (m[43]) begin
                        e_we   = 1;
                        e_addr = m[33:16];
                        e_data = m[15:0];
                        e_irq  = irq_en && (m[41:34] == irq_src);
                    end
                end
            end
            last_acc = acc;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 rx_ready", 64'(rx_ready), 64'(q.size() < DEPTH));
            chk("R9 tx_valid", 64'(tx_valid), 64'(q.size() > 0));
            if (q.size() > 0) chk("R9 tx_msg order", 64'(tx_msg), 64'(q[0]));
            chk("R1 mem_we", 64'(mem_we), 64'(e_we));
            if (e_we) begin
                chk("R1 mem_addr", 64'(mem_addr), 64'(e_addr));
                chk("R1 mem_wdata", 64'(mem_wdata), 64'(e_data));
            end
            chk("R8 irq_pulse", 64'(irq_pulse), 64'(e_irq));
            chk("R7 net_act", 64'(net_act), 64'(e_act));
        end
    end

    function automatic logic [MW-1:0] mk(bit t, bit lp, logic [7:0] s, logic [17:0] a, logic [15:0] d);
        return {t, lp, s, a, d};
    endfunction

    task automatic send(input logic [MW-1:0] m);
        rx_msg   = m;
        rx_valid = 1'b1;
        do @(negedge clk); while (!last_acc);
        rx_valid = 1'b0;
    endtask

    task automatic drain();
        tx_ready = 1'b1;
        repeat (DEPTH + 2) @(negedge clk);
        tx_ready = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 rx_ready in reset", 64'(rx_ready), 64'd1);
        chk("R11 tx_valid in reset", 64'(tx_valid), 64'd0);
        chk("R11 mem_we in reset", 64'(mem_we), 64'd0);
        chk("R11 pulses in reset", 64'({irq_pulse, net_act}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R4: non-master data from node 3, loop flag kept as received
        send(mk(1, 1, 8'h03, 18'h2ABCD, 16'hBEEF));
        chk("R1 write strobe", 64'(mem_we), 64'd1);
        chk("R4 unchanged copy", 64'(tx_msg), 64'(mk(1, 1, 8'h03, 18'h2ABCD, 16'hBEEF)));
        drain();

        // R2: status message forwarded, no write
        send(mk(0, 0, 8'h09, 18'h00011, 16'h1234));
        chk("R2 no write", 64'(mem_we), 64'd0);
        chk("R2 forwarded", 64'(tx_valid), 64'd1);
        drain();

        // R3: own message removed
        send(mk(1, 0, 8'h05, 18'h00001, 16'h0001));
        chk("R3 no write", 64'(mem_we), 64'd0);
        chk("R3 not forwarded", 64'(tx_valid), 64'd0);

        // R8: interrupt source match, mismatch, disabled
        irq_en = 1'b1; irq_src = 8'h07;
        send(mk(1, 0, 8'h07, 18'h00100, 16'hAAAA));
        chk("R8 match raises", 64'(irq_pulse), 64'd1);
        send(mk(1, 0, 8'h08, 18'h00101, 16'hBBBB));
        chk("R8 other source quiet", 64'(irq_pulse), 64'd0);
        send(mk(0, 0, 8'h07, 18'h00102, 16'hCCCC));
        chk("R8 status quiet", 64'(irq_pulse), 64'd0);
        drain();
        irq_en = 1'b0;
        send(mk(1, 0, 8'h07, 18'h00103, 16'hDDDD));
        chk("R8 disabled quiet", 64'(irq_pulse), 64'd0);
        drain();

        // R5 / R6: master mode
        master_en = 1'b1;
        send(mk(1, 0, 8'h0A, 18'h3FFFF, 16'hFFFF));
        chk("R5 loop flag set", 64'(tx_msg[42]), 64'd1);
        drain();
        send(mk(1, 1, 8'h0B, 18'h00200, 16'h5555));
        chk("R6 orphan no write", 64'(mem_we), 64'd0);
        chk("R6 orphan not forwarded", 64'(tx_valid), 64'd0);
        chk("R6 no activity", 64'(net_act), 64'd0);
        master_en = 1'b0;

        // R10: fill FIFO under backpressure, then release
        for (int i = 0; i < DEPTH; i++)
            send(mk(1, 0, 8'(8'h10 + i), 18'(i), 16'(16'h7000 + i)));
        chk("R10 full deasserts ready", 64'(rx_ready), 64'd0);
        rx_msg = mk(1, 0, 8'h20, 18'h00050, 16'h9999);
        rx_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 held off", 64'(rx_ready), 64'd0);
        tx_ready = 1'b1;
        do @(negedge clk); while (!last_acc);
        rx_valid = 1'b0;
        repeat (DEPTH + 3) @(negedge clk);
        chk("R9 all drained", 64'(tx_valid), 64'd0);

        // streaming with simultaneous push and pop
        for (int i = 0; i < 20; i++)
            send(mk(1'(i % 3 != 0), 1'(i % 2), 8'(i % 8), 18'(i * 77), 16'(i * 311)));
        repeat (DEPTH + 3) @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule